// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block produces the serial clock for a SPI master from the system clock. The division ratio is the product of two factors, each picked from a fixed table by a small code. The prescaler code chooses 2, 3, 5 or 7. The scaler code chooses one of sixteen values. The first four scaler values are 2, 4, 6 and 8, and the remaining twelve are powers of two from 16 up to 32768. The resulting serial clock can idle high or low, and the data can be captured on either the first or the second edge of each bit. The block also produces one-clock strobes that tell an adjacent shift engine when to sample incoming data and when to launch the next outgoing bit.

A one-cycle start pulse begins a frame of 4 to 16 bits. The block captures all of its settings at the moment the start pulse is accepted. It then produces two serial-clock edges per bit. One system clock after the last edge, it signals the end of the frame with a single-cycle done pulse. The settings are not re-read until the next frame begins.

Top module: `spi_baud_gen`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, `sample_stb`, `launch_stb` and `frame_done` are 0 and `sck` equals `cpol`.
- R2: While no frame is running, `sck` follows the `cpol` input with no register delay.
- R3: Each phase of `sck` (high or low) lasts H = P·S/2 system clocks. P is indexed by `presc_code` 0..3 and is 2, 3, 5 or 7. S is indexed by `scale_code`: codes 0..3 give 2, 4, 6 and 8, and a code c from 4 to 15 gives 2^c. The first edge of `sck` lands H clocks after the clock edge that accepts `start`.
- R4: A frame of N bits makes exactly 2N `sck` edges and then leaves `sck` at the idle level. N is `frame_bits`, raised to 4 if it is below 4 and lowered to 16 if it is above 16.
- R5: With `cpha` = 0, `sample_stb` pulses after edges 1, 3, … , 2N−1, and `launch_stb` pulses after edges 2, 4, … , 2N−2. Each strobe is high for one cycle, and that cycle is the first cycle in which `sck` shows its new level.
- R6: With `cpha` = 1, `launch_stb` pulses after edges 1, 3, … , 2N−1, and `sample_stb` pulses after edges 2, 4, … , 2N. The one-cycle timing is the same as in R5.
- R7: `frame_done` is high for exactly one cycle, one system clock after the 2N-th edge.
- R8: Changes to `presc_code`, `scale_code`, `cpha` or `frame_bits` during a frame do not affect that frame.
- R9: A `start` pulse is ignored while a frame is running. This includes the cycle between the last edge and `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a frame |
| presc_code | input | 2 | Prescaler selection code |
| scale_code | input | 4 | Scaler selection code |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on odd edges; 1: sample on even edges |
| frame_bits | input | 5 | Bits per frame (clamped to 4..16) |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | Capture strobe for the shift engine |
| launch_stb | output | 1 | Shift-out strobe for the shift engine |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
If the latched half-period or the phase counter holds a wrong value, the very first `sck` edge moves away from the H-th clock after start, so such a fault shows up within one half-period. If the edge counter or the frame-length clamp is wrong, the frame has the wrong number of strobe pulses and `frame_done` appears early or late. That shows up at the end of the first frame. The bench compares every output in every cycle of each frame, plus a span after the frame in which nothing may happen, against a timeline it computes for itself. It also changes settings and pulses start in the middle of a frame.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

    localparam int PRE_W     = 2;
    localparam int SCL_W     = 4;
    localparam int BITS_W    = 5;
    localparam int FRAME_MIN = 4;
    localparam int FRAME_MAX = 16;
    localparam int HALF_MAX  = 7 * 32768 / 2;
    localparam int HALF_W    = $clog2(HALF_MAX + 1);
    localparam int EDGE_W    = $clog2(2 * FRAME_MAX + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    typedef struct packed {
        logic              cpha;
        logic [EDGE_W-1:0] edges;
    } frame_cfg_t;

    function automatic int unsigned presc_factor(logic [PRE_W-1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 3;
            2'd2:    return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int unsigned scale_factor(logic [SCL_W-1:0] code);
        if (code < 4'd4)
            return 2 * (int'(code) + 1);
        return 32'd1 << code;
    endfunction

    function automatic logic [HALF_W-1:0] half_len(logic [PRE_W-1:0] p,
                                                  logic [SCL_W-1:0] s);
        int unsigned prod;
        prod = presc_factor(p) * scale_factor(s);
        return HALF_W'(prod / 2);
    endfunction

endpackage

// File: rtl/spi_baud_divider.sv
module spi_baud_divider
    import spi_baud_pkg::*;
#(
    parameter int P_W = PRE_W,
    parameter int S_W = SCL_W,
    parameter int H_W = HALF_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           run,
    input  logic [P_W-1:0] presc_code,
    input  logic [S_W-1:0] scale_code,
    output logic           tick
);

    logic [H_W-1:0] half_q;
    logic [H_W-1:0] cnt_q;
    logic           at_end;

    assign at_end = (cnt_q == half_q - 1'b1);
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= H_W'(half_len('0, '0));
            cnt_q  <= '0;
        end else if (load) begin
            half_q <= H_W'(half_len(presc_code, scale_code));
            cnt_q  <= '0;
        end else if (run) begin
            if (at_end)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_sck_shaper.sv
module spi_sck_shaper
    import spi_baud_pkg::*;
#(
    parameter int E_W = EDGE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           cpol_in,
    input  logic           cpha_in,
    input  logic [E_W-1:0] edges_in,
    input  logic           tick,
    output logic           sck,
    output logic           sample_stb,
    output logic           launch_stb,
    output logic           frame_done,
    output logic           busy
);

    phase_e         phase_q;
    logic           cpha_q;
    logic [E_W-1:0] edges_q;
    logic [E_W-1:0] edge_cnt_q;
    logic [E_W-1:0] edge_nxt;
    logic           sck_q;
    logic           samp_q;
    logic           lnch_q;
    logic           done_q;
    logic           odd_edge;
    logic           last_edge;

    assign edge_nxt  = edge_cnt_q + 1'b1;
    assign odd_edge  = edge_nxt[0];
    assign last_edge = (edge_nxt == edges_q);

    assign busy       = (phase_q != PH_IDLE);
    assign sck        = busy ? sck_q : cpol_in;
    assign sample_stb = samp_q;
    assign launch_stb = lnch_q;
    assign frame_done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            cpha_q     <= 1'b0;
            edges_q    <= '0;
            edge_cnt_q <= '0;
            sck_q      <= 1'b0;
            samp_q     <= 1'b0;
            lnch_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            samp_q <= 1'b0;
            lnch_q <= 1'b0;
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (load) begin
                        cpha_q     <= cpha_in;
                        edges_q    <= edges_in;
                        edge_cnt_q <= '0;
                        sck_q      <= cpol_in;
                        phase_q    <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (tick) begin
                        sck_q      <= ~sck_q;
                        edge_cnt_q <= edge_nxt;
                        samp_q     <= cpha_q ? !odd_edge : odd_edge;
                        lnch_q     <= cpha_q ? odd_edge : (!odd_edge && !last_edge);
                        if (last_edge)
                            phase_q <= PH_TAIL;
                    end
                end
                PH_TAIL: begin
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_baud_pkg::*;
#(
    parameter int P_W    = PRE_W,
    parameter int S_W    = SCL_W,
    parameter int B_W    = BITS_W,
    parameter int F_MIN  = FRAME_MIN,
    parameter int F_MAX  = FRAME_MAX
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [P_W-1:0] presc_code,
    input  logic [S_W-1:0] scale_code,
    input  logic           cpol,
    input  logic           cpha,
    input  logic [B_W-1:0] frame_bits,
    output logic           sck,
    output logic           sample_stb,
    output logic           launch_stb,
    output logic           frame_done
);

    localparam int E_W = $clog2(2 * F_MAX + 1);
    localparam int H_W = HALF_W;

    logic           busy;
    logic           accept;
    logic           tick;
    logic [B_W-1:0] bits_c;
    frame_cfg_t     cfg;

    always_comb begin
        if (int'(frame_bits) < F_MIN)
            bits_c = B_W'(F_MIN);
        else if (int'(frame_bits) > F_MAX)
            bits_c = B_W'(F_MAX);
        else
            bits_c = frame_bits;
        cfg.cpha  = cpha;
        cfg.edges = E_W'(2 * int'(bits_c));
    end

    assign accept = start && !busy;

    spi_baud_divider #(
        .P_W (P_W),
        .S_W (S_W),
        .H_W (H_W)
    ) div_i (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .run        (busy),
        .presc_code (presc_code),
        .scale_code (scale_code),
        .tick       (tick)
    );

    spi_sck_shaper #(
        .E_W (E_W)
    ) shp_i (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .cpol_in    (cpol),
        .cpha_in    (cfg.cpha),
        .edges_in   (cfg.edges),
        .tick       (tick),
        .sck        (sck),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb),
        .frame_done (frame_done),
        .busy       (busy)
    );

endmodule

// File: rtl/spi_baud_chk.sv
module spi_baud_chk (
    input logic clk,
    input logic rst,
    input logic cpol,
    input logic sck,
    input logic sample_stb,
    input logic launch_stb,
    input logic frame_done,
    input logic busy
);

    // R1: outputs are quiet in the first cycle after reset is released
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (!sample_stb && !launch_stb && !frame_done));

    // R5 and R6: sample and launch never coincide
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && launch_stb));

    // R4: a strobe appears only in a cycle where sck has just changed
    a_r4_strobe_on_edge: assert property (@(posedge clk) disable iff (rst)
        (sample_stb || launch_stb) |-> (sck != $past(sck)));

    // R7: the done pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7: the done pulse is seen only once the block is idle at the idle level
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!busy && sck == cpol));

endmodule

bind spi_baud_gen spi_baud_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpol       (cpol),
    .sck        (sck),
    .sample_stb (sample_stb),
    .launch_stb (launch_stb),
    .frame_done (frame_done),
    .busy       (busy)
);

// File: tb/spi_baud_gen_tb_top.sv
module spi_baud_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [1:0] presc_code;
    logic [3:0] scale_code;
    logic       cpol;
    logic       cpha;
    logic [4:0] frame_bits;
    logic       sck;
    logic       sample_stb;
    logic       launch_stb;
    logic       frame_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_baud_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .presc_code (presc_code),
        .scale_code (scale_code),
        .cpol       (cpol),
        .cpha       (cpha),
        .frame_bits (frame_bits),
        .sck        (sck),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb),
        .frame_done (frame_done)
    );

    function automatic int bench_pre(int c);
        int t[4] = '{2, 3, 5, 7};
        return t[c];
    endfunction

    function automatic int bench_scl(int c);
        int t[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024,
                      2048, 4096, 8192, 16384, 32768};
        return t[c];
    endfunction

    function automatic int bench_bits(int fb);
        if (fb < 4) return 4;
        if (fb > 16) return 16;
        return fb;
    endfunction

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // mode 0: plain, 1: change settings and pulse start mid-frame, 2: pulse start in tail
    task automatic run_frame(input int p, input int s, input bit pol,
                             input bit pha, input int fb, input int mode);
        int h, n, last, j_end;
        int bad_sck, bad_smp, bad_lau, bad_done;
        int first_sck, first_smp, first_lau, first_done;
        string rs, rp;
        h = bench_pre(p) * bench_scl(s) / 2;
        n = bench_bits(fb);
        last = 2 * n * h;
        j_end = last + h + 3;
        bad_sck = 0; bad_smp = 0; bad_lau = 0; bad_done = 0;
        first_sck = -1; first_smp = -1; first_lau = -1; first_done = -1;
        @(negedge clk);
        presc_code = 2'(p); scale_code = 4'(s);
        cpol = pol; cpha = pha; frame_bits = 5'(fb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 1; j <= j_end; j++) begin
            int k;
            bit e_sck, e_smp, e_lau, e_done, on_edge;
            @(negedge clk);
            k = j / h;
            if (k > 2 * n) k = 2 * n;
            on_edge = (j % h == 0) && (j / h >= 1) && (j / h <= 2 * n);
            e_sck  = pol ^ k[0];
            e_smp  = on_edge && (pha ? !k[0] : k[0]);
            e_lau  = on_edge && (pha ? k[0] : (!k[0] && k != 2 * n));
            e_done = (j == last + 1);
            if (sck != e_sck) begin bad_sck++; if (first_sck < 0) first_sck = j; end
            if (sample_stb != e_smp) begin bad_smp++; if (first_smp < 0) first_smp = j; end
            if (launch_stb != e_lau) begin bad_lau++; if (first_lau < 0) first_lau = j; end
            if (frame_done != e_done) begin bad_done++; if (first_done < 0) first_done = j; end
            if (mode == 1 && j == h + 1) begin
                presc_code = 2'(p ^ 1); scale_code = 4'(s ^ 1);
                cpha = !pha; frame_bits = 5'(fb + 3);
                start = 1'b1;
            end
            if (mode == 1 && j == h + 2) start = 1'b0;
            if (mode == 2 && j == last) start = 1'b1;
            if (mode == 2 && j == last + 1) start = 1'b0;
        end
        rs = (mode == 1) ? "R8" : (mode == 2) ? "R9" : "R3";
        rp = pha ? "R6" : "R5";
        if (first_sck >= 0)
            $display("  sck first mismatch at cycle %0d of frame", first_sck);
        check(rs, "sck mismatch cycles", bad_sck, 0);
        check(rp, "sample_stb mismatch cycles", bad_smp, 0);
        check(rp, "launch_stb mismatch cycles", bad_lau, 0);
        check((mode == 2) ? "R9" : "R7", "frame_done mismatch cycles", bad_done, 0);
        if (first_smp >= 0 || first_lau >= 0 || first_done >= 0)
            $display("  strobe first mismatch cycles %0d %0d %0d", first_smp, first_lau, first_done);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1977);
        rst = 1'b1; start = 1'b0; presc_code = '0; scale_code = '0;
        cpol = 1'b0; cpha = 1'b0; frame_bits = 5'd8;
        repeat (3) @(negedge clk);
        // R1: during reset
        check("R1", "sck in reset", sck, 0);
        check("R1", "strobes in reset", sample_stb | launch_stb | frame_done, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "strobes after reset", sample_stb | launch_stb | frame_done, 0);
        // R2: idle level follows cpol immediately
        cpol = 1'b1; #0.5;
        check("R2", "idle sck high", sck, 1);
        cpol = 1'b0; #0.5;
        check("R2", "idle sck low", sck, 0);

        // directed corners: R3, R4, R5, R6, R7
        run_frame(0, 0, 0, 0, 4, 0);
        run_frame(3, 0, 1, 1, 16, 0);
        run_frame(1, 2, 0, 1, 8, 0);
        run_frame(2, 3, 1, 0, 5, 0);
        run_frame(0, 8, 0, 0, 4, 0);
        run_frame(3, 9, 1, 1, 4, 0);
        // R4: frame length clamps
        run_frame(0, 1, 0, 0, 2, 0);
        run_frame(1, 0, 1, 1, 25, 0);
        // R8 and R9: mid-frame changes and start pulses
        run_frame(1, 1, 0, 0, 6, 1);
        run_frame(2, 2, 1, 1, 9, 1);
        run_frame(0, 0, 0, 1, 4, 2);
        run_frame(3, 1, 1, 0, 7, 2);
        // random frames
        for (int i = 0; i < 10; i++) begin
            int rp, rsc, rfb;
            bit rpol, rpha;
            rp   = int'($urandom_range(0, 3));
            rsc  = int'($urandom_range(0, 4));
            rfb  = int'($urandom_range(4, 16));
            rpol = 1'($urandom_range(0, 1));
            rpha = 1'($urandom_range(0, 1));
            run_frame(rp, rsc, rpol, rpha, rfb, 0);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule